// File: doc/BRIEF.md
# Single-Precision Reciprocal Square-Root Estimator

This block takes one IEEE-754 single-precision operand and produces a coarse estimate of its reciprocal square root, also in single precision. It raises an invalid-operation flag and a divide-by-zero flag alongside the result. It is intended as the seed for a software or hardware refinement loop. The estimate is therefore bit-exact to a fixed quantized rule and is not a rounded square root.

The operand is first sorted into a special class: NaN, zero or subnormal, negative, positive infinity, or positive normal. Only positive normals reach the estimate path. On that path, the parity of the biased exponent picks one of two significand grids. Seven fraction bits index a 256-entry constant table, which is computed at elaboration time with exact integer arithmetic. The result exponent comes from a halving subtraction. The output and both flags are registered, so every result appears one clock after its operand.

Top module: `rsqe_top`

## Requirements
- R1: While the active-low reset `rstN` is low, `resultOut` is 0 and both flags are 0, whatever `opIn` holds.
- R2: A quiet NaN operand (exponent field 0xFF, fraction nonzero, fraction bit 22 set) gives the default NaN 0x7FC00000 with neither flag raised.
- R3: A signaling NaN operand (exponent field 0xFF, fraction nonzero, fraction bit 22 clear) gives 0x7FC00000 and raises `flagInvalid`.
- R4: An operand whose exponent field is 0 (zero or subnormal, of either sign) gives infinity carrying the operand's sign bit (bit 31) with exponent 0xFF and fraction 0, and raises `flagDivZero`.
- R5: A negative operand that is neither NaN nor of exponent field 0 (negative infinity included) gives 0x7FC00000 and raises `flagInvalid`.
- R6: The operand 0x7F800000 (positive infinity) gives 0x00000000 with no flag raised.
- R7: For a positive normal operand with biased exponent e and fraction f, let q = 128 + f[22:16]. Let N = 512 when e[0] (operand bit 23) is 1, and N = 256 when it is 0. Then s = floor(256/sqrt((q+0.5)/N) + 0.5), which lies in 256..511. The result fraction field is s[7:0] in bits 22:15, with bits 14:0 zero.
- R8: For a positive normal operand, the result exponent field (bits 30:23) is (380 - e)/2 with integer division, the sign bit is 0, and neither flag is raised.
- R9: For a positive normal operand, fraction bits 15:0 have no effect on the result.
- R10: Each result and its flags appear after the first rising clock edge that samples the operand. Until that edge, the previous result is held.
- R11: `flagInvalid` and `flagDivZero` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opIn | input | 32 | Single-precision operand |
| resultOut | output | 32 | Registered single-precision estimate |
| flagInvalid | output | 1 | Registered invalid-operation flag |
| flagDivZero | output | 1 | Registered divide-by-zero flag |

## Verification
The block has no state apart from its output register. Any internal fault therefore shows up at the ports one clock after the operand that exposes it. A corrupted table entry changes bits 22:15 only for the operands that index that entry, so the bench sweeps all 256 indices against an independent real-valued model. A wrong class decode or a wrong strobe priority shows up as a wrong flag pairing or a non-default NaN in the very next cycle. A slip in the exponent halving shows up as an off-by-one exponent, which the bench catches by using both parities and both extremes of the exponent range.

// File: rtl/rsqe_pkg.sv
package rsqe_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int IDX_W   = 7;
  localparam int EST_W   = 8;
  localparam int TBL_DEPTH = 2 ** (IDX_W + 1);
  localparam int EXP_BIAS  = 2 ** (EXP_W - 1) - 1;
  // Numerator of the halved exponent: three biases less one keeps parity right.
  localparam int EXP_NUM   = 3 * EXP_BIAS - 1;
  localparam logic [WORD_W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef logic [EST_W-1:0] estEntry_t;

  // Strobes from the operand classifier to the datapath.
  typedef struct packed {
    logic pickNan;
    logic pickInf;
    logic pickZero;
    logic pickEst;
    logic infNeg;
    logic raiseInvalid;
    logic raiseDivZero;
    logic oddExp;
  } ctrlStrobes_t;

  // Exact integer form of s = floor(2^EST_W * sqrt(N/(q+0.5)) + 0.5):
  // s is the largest value with (2s-1)^2 * (2q+1) <= 2^(2*EST_W+3) * N.
  function automatic estEntry_t estimateEntry(input int unsigned index);
    longint unsigned qVal;
    longint unsigned limit;
    longint unsigned trial;
    longint unsigned cand;
    longint unsigned lhs;
    int gridLog;
    cand = 64'd0;
    gridLog = (((index >> IDX_W) & 1) != 0) ? IDX_W + 2 : IDX_W + 1;
    qVal  = 64'(2 ** IDX_W) + 64'(index % (2 ** IDX_W));
    limit = 64'd1 << (2 * EST_W + 3 + gridLog);
    for (int b = EST_W; b >= 0; b--) begin
      trial = cand | (64'd1 << b);
      lhs = (64'd2 * trial - 64'd1) * (64'd2 * trial - 64'd1) * (64'd2 * qVal + 64'd1);
      if (lhs <= limit) cand = trial;
    end
    return estEntry_t'(cand);
  endfunction
endpackage

// File: rtl/rsqe_classify.sv
module rsqe_classify
  import rsqe_pkg::*;
(
  input  logic [WORD_W-1:0] opWord,
  output ctrlStrobes_t      strobes
);
  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic expOnes, expNone, fracNone;
  logic isNan, isSignaling, isNegative, isPosInf;

  assign signBit   = opWord[WORD_W-1];
  assign expField  = opWord[FRAC_W +: EXP_W];
  assign fracField = opWord[FRAC_W-1:0];

  assign expOnes  = &expField;
  assign expNone  = ~|expField;
  assign fracNone = ~|fracField;

  // Priority: NaN, then zero/subnormal, then negative, then +inf.
  assign isNan       = expOnes & ~fracNone;
  assign isSignaling = isNan & ~fracField[FRAC_W-1];
  assign isNegative  = signBit & ~isNan & ~expNone;
  assign isPosInf    = expOnes & fracNone & ~signBit;

  always_comb begin
    strobes = '0;
    strobes.pickNan      = isNan | isNegative;
    strobes.pickInf      = expNone;
    strobes.pickZero     = isPosInf;
    strobes.pickEst      = ~(isNan | isNegative | expNone | isPosInf);
    strobes.infNeg       = signBit;
    strobes.raiseInvalid = isSignaling | isNegative;
    strobes.raiseDivZero = expNone;
    strobes.oddExp       = expField[0];
  end
endmodule

// File: rtl/rsqe_datapath.sv
module rsqe_datapath
  import rsqe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [EXP_W-1:0]  expField,
  input  logic [IDX_W-1:0]  fracTop,
  input  ctrlStrobes_t      strobes,
  output logic [WORD_W-1:0] resultWord,
  output logic              invalidQ,
  output logic              divZeroQ
);
  localparam int PAD_W = FRAC_W - EST_W;

  estEntry_t tableWord [TBL_DEPTH];

  for (genvar i = 0; i < TBL_DEPTH; i++) begin : g_tbl
    localparam estEntry_t ENTRY = estimateEntry(i);
    assign tableWord[i] = ENTRY;
  end

  logic [IDX_W:0]    tblIdx;
  estEntry_t         estFrac;
  logic [EXP_W-1:0]  estExp;
  logic [WORD_W-1:0] nextWord;

  assign tblIdx  = {strobes.oddExp, fracTop};
  assign estFrac = tableWord[tblIdx];
  assign estExp  = EXP_W'((EXP_NUM - int'(expField)) >> 1);

  always_comb begin
    nextWord = '0;
    if (strobes.pickNan)
      nextWord = DEFAULT_NAN;
    else if (strobes.pickInf)
      nextWord = {strobes.infNeg, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (strobes.pickZero)
      nextWord = '0;
    else if (strobes.pickEst)
      nextWord = {1'b0, estExp, estFrac, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultWord <= '0;
      invalidQ   <= 1'b0;
      divZeroQ   <= 1'b0;
    end else begin
      resultWord <= nextWord;
      invalidQ   <= strobes.raiseInvalid;
      divZeroQ   <= strobes.raiseDivZero;
    end
  end
endmodule

// File: rtl/rsqe_top.sv
module rsqe_top
  import rsqe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] opIn,
  output logic [WORD_W-1:0] resultOut,
  output logic              flagInvalid,
  output logic              flagDivZero
);
  ctrlStrobes_t strobes;

  rsqe_classify u_classify (
    .opWord  (opIn),
    .strobes (strobes)
  );

  rsqe_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .expField   (opIn[FRAC_W +: EXP_W]),
    .fracTop    (opIn[FRAC_W-1 -: IDX_W]),
    .strobes    (strobes),
    .resultWord (resultOut),
    .invalidQ   (flagInvalid),
    .divZeroQ   (flagDivZero)
  );
endmodule

// File: rtl/rsqe_checker.sv
module rsqe_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] opIn,
  input logic [31:0] resultOut,
  input logic        flagInvalid,
  input logic        flagDivZero
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R3 / R5: an invalid flag always comes with the default NaN
  a_r5_invalid_nan: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> (resultOut == 32'h7FC00000));

  // R4: divide-by-zero always comes with an infinity
  a_r4_divzero_inf: assert property (@(posedge clk) disable iff (!rstN)
    flagDivZero |-> (resultOut[30:0] == 31'h7F800000));

  // R11: flags are exclusive
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagInvalid, flagDivZero}));

  // R8 / R10: exponent of the previous cycle's positive normal operand
  a_r8_exponent_half: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(opIn[31] == 1'b0 && opIn[30:23] != 8'h00 && opIn[30:23] != 8'hFF))
    |-> ((({1'b0, resultOut[30:23], 1'b0} + {2'b00, $past(opIn[30:23])}) == 10'd380) ||
         (({1'b0, resultOut[30:23], 1'b0} + {2'b00, $past(opIn[30:23])}) == 10'd379)));

  // R8: a positive normal operand raises no flag and gives a positive result
  a_r8_normal_clean: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(opIn[31] == 1'b0 && opIn[30:23] != 8'h00 && opIn[30:23] != 8'hFF))
    |-> (!flagInvalid && !flagDivZero && !resultOut[31]));

  // R6: positive infinity one cycle later gives +0
  a_r6_posinf_zero: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(opIn) == 32'h7F800000) |-> (resultOut == 32'h0 && !flagInvalid));
endmodule

bind rsqe_top rsqe_checker u_chk (.*);

// File: tb/rsqe_top_test.sv
module rsqe_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opIn = 32'h0;
  logic [31:0] resultOut;
  logic        flagInvalid;
  logic        flagDivZero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rsqe_top uut (
    .clk(clk), .rstN(rstN), .opIn(opIn),
    .resultOut(resultOut), .flagInvalid(flagInvalid), .flagDivZero(flagDivZero)
  );

  // Reference model from the requirements: {invalid, divzero, word}
  function automatic logic [33:0] refModel(input logic [31:0] v);
    logic [7:0]  e;
    logic [22:0] f;
    int q;
    int ex;
    int s;
    real grid;
    real r;
    logic [8:0] sBits;
    logic [7:0] exBits;
    e = v[30:23];
    f = v[22:0];
    if (e == 8'hFF && f != 0) return {~f[22], 1'b0, 32'h7FC00000};
    if (e == 8'h00)           return {1'b0, 1'b1, v[31], 31'h7F800000};
    if (v[31])                return {1'b1, 1'b0, 32'h7FC00000};
    if (e == 8'hFF)           return {2'b00, 32'h0};
    q = 128 + int'(f[22:16]);
    grid = e[0] ? 512.0 : 256.0;
    r = 1.0 / $sqrt((q + 0.5) / grid);
    s = $rtoi($floor(256.0 * r + 0.5));
    ex = (380 - int'(e)) / 2;
    sBits = s[8:0];
    exBits = ex[7:0];
    return {2'b00, 1'b0, exBits, sBits[7:0], 15'h0};
  endfunction

  task automatic expectNow(input string req, input logic [33:0] exp);
    checks++;
    if ({flagInvalid, flagDivZero, resultOut} !== exp) begin
      errors++;
      $display("FAIL %s: got inv=%0b dz=%0b word=%08h expected inv=%0b dz=%0b word=%08h",
               req, flagInvalid, flagDivZero, resultOut, exp[33], exp[32], exp[31:0]);
    end
    checks++;
    if (flagInvalid && flagDivZero) begin
      errors++;
      $display("FAIL R11: got both flags high expected at most one");
    end
  endtask

  task automatic apply(input string req, input logic [31:0] v);
    @(negedge clk);
    opIn = v;
    @(negedge clk);
    expectNow(req, refModel(v));
  endtask

  task automatic test_reset;
    opIn = 32'h3F800000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectNow("R1 reset", 34'h0);
    rstN = 1'b1;
  endtask

  task automatic test_table_sweep;
    for (int i = 0; i < 256; i++) begin
      logic [7:0]  e;
      logic [15:0] low;
      e = (i >= 128) ? 8'd127 : 8'd128;
      low = 16'(i * 37);
      apply("R7 table", {1'b0, e, i[6:0], low});
    end
  endtask

  task automatic test_exponents;
    logic [7:0] eList [8] = '{8'd1, 8'd2, 8'd100, 8'd127, 8'd128, 8'd200, 8'd253, 8'd254};
    for (int k = 0; k < 8; k++)
      apply("R8 exponent", {1'b0, eList[k], 7'(k * 19), 16'hA5A5});
  endtask

  task automatic test_low_bits;
    logic [31:0] first;
    logic [33:0] base;
    first = {1'b0, 8'd131, 7'h2C, 16'h0000};
    base = refModel(first);
    apply("R9 base", first);
    apply("R9 low bits ignored", {1'b0, 8'd131, 7'h2C, 16'hFFFF});
    checks++;
    if (resultOut !== base[31:0]) begin
      errors++;
      $display("FAIL R9: got %08h expected %08h", resultOut, base[31:0]);
    end
  endtask

  task automatic test_nans;
    apply("R2 quiet NaN", 32'h7FC00000);
    apply("R2 quiet NaN neg", 32'hFFC12345);
    apply("R3 signaling NaN", 32'h7F800001);
    apply("R3 signaling NaN neg", 32'hFFA00000);
  endtask

  task automatic test_zero_denorm;
    apply("R4 +zero", 32'h00000000);
    apply("R4 -zero", 32'h80000000);
    apply("R4 +denormal", 32'h00400001);
    apply("R4 -denormal", 32'h807FFFFF);
  endtask

  task automatic test_negative;
    apply("R5 -1.0", 32'hBF800000);
    apply("R5 -inf", 32'hFF800000);
    apply("R5 -min normal", 32'h80800000);
  endtask

  task automatic test_posinf;
    apply("R6 +inf", 32'h7F800000);
  endtask

  task automatic test_latency;
    logic [33:0] prev;
    apply("R10 setup", 32'h40800000);
    prev = refModel(32'h40800000);
    @(negedge clk);
    opIn = 32'h00000000;
    #1;
    expectNow("R10 hold before edge", prev);
    @(negedge clk);
    expectNow("R10 after edge", refModel(32'h00000000));
  endtask

  initial begin
    test_reset();
    test_table_sweep();
    test_exponents();
    test_low_bits();
    test_nans();
    test_zero_denorm();
    test_negative();
    test_posinf();
    test_latency();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule